// File: doc/BRIEF.md
# Byte Table Lookup Unit

The unit assembles a 32-bit word from four byte-wide indices carried in one request word. Each index picks one byte out of a small local table made of 64-bit entries. The entries are treated as one contiguous byte array: entry 0 holds bytes 0 to 7, entry 1 holds bytes 8 to 15, and so on. Software-visible table contents are loaded through a plain write port, one full entry per write.

A lookup carries three operands: the index word, a default word and a limit. Any index that is not strictly below the limit does not read the table. Instead, its result lane passes the byte in the same lane of the default word. This lets a caller chain several lookups over a larger table, or fill missing entries with a known value. The result and its valid flag are registered and appear on the clock edge that follows the request.

Top module: `byte_gather`

## Requirements
- R1: While `rst_n` is low and after it rises, `rsp_valid` is 0, `rsp_data` is 0 and every table byte is 0, until a load changes it.
- R2: `rsp_valid` is high in exactly the cycle after a cycle in which `req_valid` was high at the clock edge.
- R3: Result byte lane k (bits 8k+7..8k) is produced by index byte k of `req_idx` (bits 8k+7..8k), for k = 0 to 3.
- R4: An in-range index i reads table entry i[4:3], byte i[2:0] of that entry, where byte 0 is bits 7..0 of the entry.
- R5: An index is in range only when it is strictly below `req_limit`, taken as an unsigned value. An index equal to the limit is out of range.
- R6: An out-of-range index makes its result lane equal to the same lane of `req_dflt`. This includes every index of 32 or more.
- R7: With `ld_en` high, `ld_data` replaces entry `ld_addr` at the clock edge. A lookup in the same cycle returns the contents from before the write.
- R8: In a cycle after which no request was taken, `rsp_data` keeps its previous value.
- R9: With `ld_en` low, `ld_addr` and `ld_data` have no effect on the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ld_en | input | 1 | Table entry write enable |
| ld_addr | input | 2 | Entry number to write |
| ld_data | input | 64 | Entry contents, byte 0 in bits 7..0 |
| req_valid | input | 1 | Lookup request |
| req_idx | input | 32 | Four byte indices, lane 0 in bits 7..0 |
| req_dflt | input | 32 | Per-lane fallback bytes for out-of-range indices |
| req_limit | input | 6 | Indices below this value read the table |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_data | output | 32 | Assembled result word |

## Verification
The assertions assume that `req_limit` only takes the legal values 8, 16, 24 or 32 and that reset is released away from the clock edge. Under those terms, the fallback path depends only on the request operands. The stimulus draws every limit from that set of four values and changes all inputs on the falling clock edge. Indices are still allowed to range over the full byte, so values of 32 and above, and values exactly equal to the limit, are applied on purpose.

// File: rtl/byte_gather_pkg.sv
package byte_gather_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/byte_gather_table.sv
module byte_gather_table #(
  parameter int unsigned ENTRIES = 4,
  parameter int unsigned ENTRY_W = 64,
  localparam int unsigned ADDR_W = $clog2(ENTRIES)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [ENTRY_W-1:0]         wr_data,
  output logic [ENTRIES*ENTRY_W-1:0] flat_q
);
  logic [ENTRIES-1:0][ENTRY_W-1:0] mem_q;
  logic [ENTRIES-1:0][ENTRY_W-1:0] mem_d;
  logic [ENTRIES-1:0]              ent_we;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    assign ent_we[e] = wr_en && (wr_addr == ADDR_W'(e));

    always_comb begin
      mem_d[e] = mem_q[e];
      if (ent_we[e]) begin
        mem_d[e] = wr_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[e] <= '0;
      end else if (ent_we[e]) begin
        mem_q[e] <= mem_d[e];
      end
    end
  end

  assign flat_q = mem_q;
endmodule

// File: rtl/byte_gather_lane.sv
module byte_gather_lane
  import byte_gather_pkg::*;
#(
  parameter int unsigned TOTAL_BYTES = 32,
  parameter int unsigned IDX_W       = 8,
  parameter int unsigned LIMIT_W     = 6,
  localparam int unsigned ADDR_W     = $clog2(TOTAL_BYTES)
) (
  input  logic [TOTAL_BYTES*BYTE_W-1:0] table_flat,
  input  logic [IDX_W-1:0]              idx,
  input  logic [LIMIT_W-1:0]            limit,
  input  byte_t                         dflt,
  output byte_t                         lane_out
);
  logic              below_limit;
  logic              inside_table;
  logic [ADDR_W-1:0] byte_addr;
  byte_t             table_byte;

  assign below_limit  = idx < IDX_W'(limit);
  assign inside_table = idx < IDX_W'(TOTAL_BYTES);
  assign byte_addr    = idx[ADDR_W-1:0];

  always_comb begin
    table_byte = table_flat[{byte_addr, 3'b000} +: BYTE_W];
    lane_out   = (below_limit && inside_table) ? table_byte : dflt;
  end
endmodule

// File: rtl/byte_gather.sv
module byte_gather
  import byte_gather_pkg::*;
#(
  parameter int unsigned ENTRIES = 4,
  parameter int unsigned ENTRY_W = 64,
  parameter int unsigned LANES   = 4,
  parameter int unsigned LIMIT_W = 6,
  localparam int unsigned ADDR_W      = $clog2(ENTRIES),
  localparam int unsigned TOTAL_BYTES = ENTRIES * ENTRY_W / BYTE_W,
  localparam int unsigned WORD_W      = LANES * BYTE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_en,
  input  logic [ADDR_W-1:0]  ld_addr,
  input  logic [ENTRY_W-1:0] ld_data,
  input  logic               req_valid,
  input  logic [WORD_W-1:0]  req_idx,
  input  logic [WORD_W-1:0]  req_dflt,
  input  logic [LIMIT_W-1:0] req_limit,
  output logic               rsp_valid,
  output logic [WORD_W-1:0]  rsp_data
);
  logic [ENTRIES*ENTRY_W-1:0] table_flat;
  logic [WORD_W-1:0]          gathered;
  logic [WORD_W-1:0]          data_d;
  logic [WORD_W-1:0]          data_q;
  logic                       valid_q;

  byte_gather_table #(
    .ENTRIES (ENTRIES),
    .ENTRY_W (ENTRY_W)
  ) i_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ld_en),
    .wr_addr (ld_addr),
    .wr_data (ld_data),
    .flat_q  (table_flat)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    byte_gather_lane #(
      .TOTAL_BYTES (TOTAL_BYTES),
      .IDX_W       (BYTE_W),
      .LIMIT_W     (LIMIT_W)
    ) i_lane (
      .table_flat (table_flat),
      .idx        (req_idx[k*BYTE_W +: BYTE_W]),
      .limit      (req_limit),
      .dflt       (req_dflt[k*BYTE_W +: BYTE_W]),
      .lane_out   (gathered[k*BYTE_W +: BYTE_W])
    );
  end

  always_comb begin
    data_d = data_q;
    if (req_valid) begin
      data_d = gathered;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= req_valid;
      if (req_valid) begin
        data_q <= data_d;
      end
    end
  end

  assign rsp_valid = valid_q;
  assign rsp_data  = data_q;
endmodule

// File: rtl/byte_gather_chk.sv
module byte_gather_chk #(
  parameter int unsigned LANES   = 4,
  parameter int unsigned LIMIT_W = 6
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic [LANES*8-1:0]   req_idx,
  input logic [LANES*8-1:0]   req_dflt,
  input logic [LIMIT_W-1:0]   req_limit,
  input logic                 rsp_valid,
  input logic [LANES*8-1:0]   rsp_data
);
  // R2: a taken request yields a valid response on the next edge
  assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R2: no request, no response
  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R8: result word is held between requests
  assert_data_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(rsp_data));

  for (genvar k = 0; k < LANES; k++) begin : g_lane_chk
    // R6: an index at or above the limit passes the default byte of its lane
    assert_dflt_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (req_idx[k*8 +: 8] >= 8'(req_limit)))
      |=> (rsp_data[k*8 +: 8] == $past(req_dflt[k*8 +: 8])));
  end
endmodule

bind byte_gather byte_gather_chk #(
  .LANES   (LANES),
  .LIMIT_W (LIMIT_W)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_idx   (req_idx),
  .req_dflt  (req_dflt),
  .req_limit (req_limit),
  .rsp_valid (rsp_valid),
  .rsp_data  (rsp_data)
);

// File: tb/test_byte_gather.sv
module test_byte_gather;
  logic        clk;
  logic        rst_n;
  logic        ld_en;
  logic [1:0]  ld_addr;
  logic [63:0] ld_data;
  logic        req_valid;
  logic [31:0] req_idx;
  logic [31:0] req_dflt;
  logic [5:0]  req_limit;
  logic        rsp_valid;
  logic [31:0] rsp_data;

  int checks = 0;
  int errors = 0;
  bit mon_on = 0;
  bit done = 0;

  logic [7:0]  model_mem [32];
  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic [31:0] last_data;

  byte_gather i_byte_gather (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .req_valid(req_valid), .req_idx(req_idx), .req_dflt(req_dflt),
    .req_limit(req_limit), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  function automatic logic [31:0] model(logic [31:0] idx, logic [31:0] dflt, logic [5:0] lim);
    logic [31:0] r;
    for (int k = 0; k < 4; k++) begin
      logic [7:0] ix;
      ix = idx[k*8 +: 8];
      if (ix < {2'b00, lim} && ix < 8'd32) r[k*8 +: 8] = model_mem[ix[4:0]];
      else r[k*8 +: 8] = dflt[k*8 +: 8];
    end
    return r;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cycle(bit le, logic [1:0] la, logic [63:0] ld, bit rv,
                       logic [31:0] idx, logic [31:0] dflt, logic [5:0] lim, string tag);
    @(negedge clk);
    ld_en = le; ld_addr = la; ld_data = ld;
    req_valid = rv; req_idx = idx; req_dflt = dflt; req_limit = lim;
    @(posedge clk);
    #1;
    if (rv) begin
      exp_q.push_back(model(idx, dflt, lim));
      tag_q.push_back(tag);
    end
    if (le) for (int b = 0; b < 8; b++) model_mem[{la, 3'(b)}] = ld[b*8 +: 8];
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cycle(0, 2'd0, 64'h0, 0, 32'h0, 32'h0, 6'd32, "R8");
  endtask

  function automatic logic [63:0] pattern(int e);
    logic [63:0] v;
    for (int b = 0; b < 8; b++) v[b*8 +: 8] = 8'(8'h40 + e*8 + b);
    return v;
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (mon_on) begin
      if (rsp_valid) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R2 actual=valid expected=idle");
        end else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(t, rsp_data, e);
        end
        last_data = rsp_data;
      end else begin
        if (exp_q.size() != 0) begin
          checks++; errors++;
          $display("FAIL R2 actual=idle expected=valid");
          void'(exp_q.pop_front());
          void'(tag_q.pop_front());
        end
        check("R8", rsp_data, last_data);
      end
    end
  end

  initial begin
    #4_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [5:0] lims [4];
    lims = '{6'd8, 6'd16, 6'd24, 6'd32};
    rst_n = 0; ld_en = 0; ld_addr = 0; ld_data = 0;
    req_valid = 0; req_idx = 0; req_dflt = 0; req_limit = 6'd32;
    for (int i = 0; i < 32; i++) model_mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    check("R1", {31'd0, rsp_valid}, 32'd0);
    check("R1", rsp_data, 32'd0);
    rst_n = 1;
    @(negedge clk);
    check("R1", {31'd0, rsp_valid}, 32'd0);
    last_data = 32'd0;
    mon_on = 1;

    // R1: cleared table reads zero
    cycle(0, 0, 0, 1, 32'h1F10_0800, 32'hFFFF_FFFF, 6'd32, "R1");
    // load all entries
    for (int e = 0; e < 4; e++) cycle(1, 2'(e), pattern(e), 0, 0, 0, 6'd32, "R7");
    idle(1);
    // R3/R4: lane order and entry/byte split
    cycle(0, 0, 0, 1, 32'h0302_0100, 32'h0, 6'd32, "R3");
    cycle(0, 0, 0, 1, 32'h1F18_0F07, 32'h0, 6'd32, "R4");
    cycle(0, 0, 0, 1, 32'h0011_1A05, 32'h0, 6'd32, "R4");
    // R5/R6: equality to limit and above
    cycle(0, 0, 0, 1, 32'h0807_0010, 32'hDDCC_BBAA, 6'd8, "R5");
    cycle(0, 0, 0, 1, 32'h0F10_170F, 32'h1122_3344, 6'd16, "R5");
    cycle(0, 0, 0, 1, 32'h1718_0019, 32'h5566_7788, 6'd24, "R5");
    cycle(0, 0, 0, 1, 32'hFF20_1F80, 32'hA1B2_C3D4, 6'd32, "R6");
    idle(2);
    // R9: write data with enable low
    cycle(0, 2'd1, 64'hDEAD_BEEF_DEAD_BEEF, 0, 0, 0, 6'd32, "R9");
    cycle(0, 0, 0, 1, 32'h0F0C_0908, 32'h0, 6'd32, "R9");
    // R7: write and lookup in the same cycle, then after
    cycle(1, 2'd2, 64'h0123_4567_89AB_CDEF, 1, 32'h1714_1110, 32'h0, 6'd32, "R7");
    cycle(0, 0, 0, 1, 32'h1714_1110, 32'h0, 6'd32, "R7");
    idle(3);
    // random mix
    for (int n = 0; n < 400; n++) begin
      bit le, rv;
      logic [31:0] ix;
      le = ($urandom % 4) == 0;
      rv = ($urandom % 3) != 0;
      ix = $urandom;
      if ($urandom % 2) ix = ix & 32'h3F3F_3F3F;
      cycle(le, 2'($urandom), {$urandom, $urandom}, rv, ix, $urandom,
            lims[$urandom % 4], "R3");
    end
    idle(3);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule